// File: doc/BRIEF.md
# Instruction-Cycle Sequencer

This block is the multi-cycle control unit of a small accumulator machine. It walks every instruction through the full register-transfer path. First the program counter goes to the memory address register and a read is issued. The returned word is caught in the memory data register, which then loads the instruction register. After that the instruction is decoded, an effective address is optionally read through memory, and one or more execute steps follow. Between instructions it may run a four-step interrupt cycle. That cycle saves the program counter to a fixed memory cell and redirects fetching to a fixed service routine.

The unit drives a single synchronous memory port. Read data returns on the clock after the read strobe. It holds the PC, MAR, MDR (which doubles as the buffer for the interrupt save), IR and the accumulator, together with one interrupt-enable flag. Its current state code is brought out, so the exact state sequence can be observed.

Top module: `icycle_seq`

## Requirements
- R1: While reset is held, the PC reads START_ADDR (0x010), the state is 0 (fetch-address), the interrupt enable is 0 and neither memory strobe is active. The first fetch read (state 1, address = START_ADDR) happens in the first cycle after reset is released.
- R2: Every fetch runs states 0, 1, 2, 3 in order. State 0 copies PC to MAR. State 1 reads memory at MAR. State 2 latches the returned word into MDR and adds 1 to the PC. State 3 copies MDR into IR.
- R3: Instruction format: bit 15 is the indirect flag, bits 14:12 are the opcode and bits 11:0 are the address. Opcodes 0 LOAD, 1 ADD, 2 STORE, 3 JUMP and 4 CALL reference memory, and 5 and 6 act as no-ops. Opcode 7 is a register/I-O operation selected by bits 3:0: 0 no-op, 1 clear AC, 2 increment AC, 3 enable interrupts, 4 disable interrupts, 5 return from interrupt.
- R4: A memory-reference instruction with bit 15 set adds exactly three states (5 read, 6 latch, 7 load MAR). Its effective address is bits 11:0 of the word read from the address field.
- R5: An opcode-7 instruction never performs the indirect read, whatever the value of bit 15.
- R6: An instruction takes 5 states for fetch and decode, plus its execute states (8 to 11): 1 for STORE, JUMP, no-ops and register/I-O operations other than return; 2 for CALL; 3 for LOAD and ADD; 4 for return from interrupt.
- R7: LOAD sets AC to M[ea]. ADD sets AC to AC+M[ea], truncated to 16 bits. STORE writes AC to M[ea]. JUMP sets PC to ea. CALL writes the return address to M[ea] and sets PC to ea+1.
- R8: After the last execute state, the sequencer enters the interrupt cycle only when the request is high and the enable (as changed by the instruction itself) is 1. Otherwise it returns to state 0.
- R9: The interrupt cycle runs states 12 to 15 in order. State 12 copies PC into MDR and clears the enable. State 13 loads SAVE_ADDR (0x008) into MAR. State 14 loads ISR_ADDR (0x040) into PC. State 15 writes MDR to SAVE_ADDR. Fetch then resumes.
- R10: While the enable is 0, a held request does not start an interrupt cycle.
- R11: Return from interrupt reads M[SAVE_ADDR] and loads its low 12 bits into the PC.
- R12: Read and write strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request level |
| memRdata | input | 16 | Read data, valid the cycle after memRd |
| memAddr | output | 12 | Memory address (MAR) |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memWdata | output | 16 | Write data |
| state | output | 4 | Current sequencer state code |
| pc | output | 12 | Program counter |
| ir | output | 16 | Instruction register |
| ac | output | 16 | Accumulator |
| intEn | output | 1 | Interrupt enable flag |

## Verification
Two functions can land in the same cycle. One is the last execute state of an instruction that itself changes the interrupt enable. The other is the between-instruction interrupt test. The bench holds the request high while an enable instruction executes, and expects the interrupt cycle to follow that same instruction. Later it holds the request high across a disable instruction and expects no interrupt cycle. Each case is judged by the number of states the instruction takes, by the recorded state trace, and by the PC, the enable flag and the save cell afterwards.

// File: rtl/icycle_pkg.sv
package icycle_pkg;

  typedef enum logic [3:0] {
    ST_FADR = 4'd0,  ST_FRD  = 4'd1,  ST_FLAT = 4'd2,  ST_FIR  = 4'd3,
    ST_DEC  = 4'd4,  ST_IRD  = 4'd5,  ST_ILAT = 4'd6,  ST_IEA  = 4'd7,
    ST_EX0  = 4'd8,  ST_EX1  = 4'd9,  ST_EX2  = 4'd10, ST_EX3  = 4'd11,
    ST_INT0 = 4'd12, ST_INT1 = 4'd13, ST_INT2 = 4'd14, ST_INT3 = 4'd15
  } seqState_e;

  typedef enum logic [1:0] {WR_AC = 2'd0, WR_MDR = 2'd1, WR_PC = 2'd2} wrSrc_e;

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_ADD   = 3'd1;
  localparam logic [2:0] OP_STORE = 3'd2;
  localparam logic [2:0] OP_JUMP  = 3'd3;
  localparam logic [2:0] OP_CALL  = 3'd4;
  localparam logic [2:0] OP_REG   = 3'd7;

  localparam logic [3:0] SUB_CLR = 4'd1;
  localparam logic [3:0] SUB_INC = 4'd2;
  localparam logic [3:0] SUB_ION = 4'd3;
  localparam logic [3:0] SUB_IOF = 4'd4;
  localparam logic [3:0] SUB_RET = 4'd5;

  typedef struct packed {
    logic   marFromPc;
    logic   marFromIr;
    logic   marFromMdr;
    logic   marSave;
    logic   pcInc;
    logic   pcFromMar;
    logic   pcFromMarInc;
    logic   pcIsr;
    logic   pcFromMdr;
    logic   mdrFromMem;
    logic   mdrFromPc;
    logic   irFromMdr;
    logic   acLoad;
    logic   acAdd;
    logic   acClr;
    logic   acInc;
    logic   memRd;
    logic   memWr;
    wrSrc_e wrSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/icycle_ctrl.sv
module icycle_ctrl
  import icycle_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irq,
  input  logic [DATA_W-1:0] ir,
  output seqState_e         curState,
  output logic              intEn,
  output ctrlStrobes_t      strb
);

  localparam int IND_BIT = DATA_W - 1;
  localparam int OP_LSB  = DATA_W - 4;

  seqState_e  nxtState;
  logic [2:0] opcode;
  logic [3:0] subOp;
  logic       indirect;
  logic       lastStep;
  logic       setIe;
  logic       clrIe;
  logic       ieAfter;

  assign opcode   = ir[IND_BIT-1:OP_LSB];
  assign subOp    = ir[3:0];
  assign indirect = ir[IND_BIT];

  always_comb begin
    strb     = '0;
    nxtState = curState;
    lastStep = 1'b0;
    setIe    = 1'b0;
    clrIe    = 1'b0;
    unique case (curState)
      ST_FADR: begin
        strb.marFromPc = 1'b1;
        nxtState       = ST_FRD;
      end
      ST_FRD: begin
        strb.memRd = 1'b1;
        nxtState   = ST_FLAT;
      end
      ST_FLAT: begin
        strb.mdrFromMem = 1'b1;
        strb.pcInc      = 1'b1;
        nxtState        = ST_FIR;
      end
      ST_FIR: begin
        strb.irFromMdr = 1'b1;
        nxtState       = ST_DEC;
      end
      ST_DEC: begin
        strb.marFromIr = 1'b1;
        if (opcode == OP_REG)  nxtState = ST_EX0;
        else if (indirect)     nxtState = ST_IRD;
        else                   nxtState = ST_EX0;
      end
      ST_IRD: begin
        strb.memRd = 1'b1;
        nxtState   = ST_ILAT;
      end
      ST_ILAT: begin
        strb.mdrFromMem = 1'b1;
        nxtState        = ST_IEA;
      end
      ST_IEA: begin
        strb.marFromMdr = 1'b1;
        nxtState        = ST_EX0;
      end
      ST_EX0: begin
        case (opcode)
          OP_LOAD, OP_ADD: begin
            strb.memRd = 1'b1;
            nxtState   = ST_EX1;
          end
          OP_STORE: begin
            strb.memWr = 1'b1;
            strb.wrSel = WR_AC;
            lastStep   = 1'b1;
          end
          OP_JUMP: begin
            strb.pcFromMar = 1'b1;
            lastStep       = 1'b1;
          end
          OP_CALL: begin
            strb.memWr = 1'b1;
            strb.wrSel = WR_PC;
            nxtState   = ST_EX1;
          end
          OP_REG: begin
            case (subOp)
              SUB_CLR: begin strb.acClr = 1'b1; lastStep = 1'b1; end
              SUB_INC: begin strb.acInc = 1'b1; lastStep = 1'b1; end
              SUB_ION: begin setIe = 1'b1;      lastStep = 1'b1; end
              SUB_IOF: begin clrIe = 1'b1;      lastStep = 1'b1; end
              SUB_RET: begin
                strb.marSave = 1'b1;
                nxtState     = ST_EX1;
              end
              default: lastStep = 1'b1;
            endcase
          end
          default: lastStep = 1'b1;
        endcase
      end
      ST_EX1: begin
        if (opcode == OP_CALL) begin
          strb.pcFromMarInc = 1'b1;
          lastStep          = 1'b1;
        end else if (opcode == OP_REG) begin
          strb.memRd = 1'b1;
          nxtState   = ST_EX2;
        end else begin
          strb.mdrFromMem = 1'b1;
          nxtState        = ST_EX2;
        end
      end
      ST_EX2: begin
        if (opcode == OP_REG) begin
          strb.mdrFromMem = 1'b1;
          nxtState        = ST_EX3;
        end else begin
          strb.acLoad = (opcode == OP_LOAD);
          strb.acAdd  = (opcode == OP_ADD);
          lastStep    = 1'b1;
        end
      end
      ST_EX3: begin
        strb.pcFromMdr = 1'b1;
        lastStep       = 1'b1;
      end
      ST_INT0: begin
        strb.mdrFromPc = 1'b1;
        clrIe          = 1'b1;
        nxtState       = ST_INT1;
      end
      ST_INT1: begin
        strb.marSave = 1'b1;
        nxtState     = ST_INT2;
      end
      ST_INT2: begin
        strb.pcIsr = 1'b1;
        nxtState   = ST_INT3;
      end
      ST_INT3: begin
        strb.memWr = 1'b1;
        strb.wrSel = WR_MDR;
        nxtState   = ST_FADR;
      end
      default: nxtState = ST_FADR;
    endcase

    ieAfter = setIe ? 1'b1 : (clrIe ? 1'b0 : intEn);
    if (lastStep) begin
      nxtState = (irq && ieAfter) ? ST_INT0 : ST_FADR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_FADR;
      intEn    <= 1'b0;
    end else begin
      curState <= nxtState;
      if (setIe)      intEn <= 1'b1;
      else if (clrIe) intEn <= 1'b0;
    end
  end

endmodule

// File: rtl/icycle_dpath.sv
module icycle_dpath
  import icycle_pkg::*;
#(
  parameter int              DATA_W     = 16,
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] START_ADDR = 12'h010,
  parameter logic [ADDR_W-1:0] SAVE_ADDR  = 12'h008,
  parameter logic [ADDR_W-1:0] ISR_ADDR   = 12'h040
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] ac
);

  localparam int PAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] mdr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= START_ADDR;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      ac  <= '0;
    end else begin
      if (strb.marFromPc)       mar <= pc;
      else if (strb.marFromIr)  mar <= ir[ADDR_W-1:0];
      else if (strb.marFromMdr) mar <= mdr[ADDR_W-1:0];
      else if (strb.marSave)    mar <= SAVE_ADDR;

      if (strb.pcInc)             pc <= pc + 1'b1;
      else if (strb.pcFromMar)    pc <= mar;
      else if (strb.pcFromMarInc) pc <= mar + 1'b1;
      else if (strb.pcIsr)        pc <= ISR_ADDR;
      else if (strb.pcFromMdr)    pc <= mdr[ADDR_W-1:0];

      if (strb.mdrFromMem)     mdr <= memRdata;
      else if (strb.mdrFromPc) mdr <= {{PAD_W{1'b0}}, pc};

      if (strb.irFromMdr) ir <= mdr;

      if (strb.acLoad)     ac <= mdr;
      else if (strb.acAdd) ac <= ac + mdr;
      else if (strb.acClr) ac <= '0;
      else if (strb.acInc) ac <= ac + 1'b1;
    end
  end

  always_comb begin
    unique case (strb.wrSel)
      WR_MDR:  memWdata = mdr;
      WR_PC:   memWdata = {{PAD_W{1'b0}}, pc};
      default: memWdata = ac;
    endcase
  end

endmodule

// File: rtl/icycle_seq.sv
module icycle_seq
  import icycle_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] START_ADDR = 12'h010,
  parameter logic [ADDR_W-1:0] SAVE_ADDR  = 12'h008,
  parameter logic [ADDR_W-1:0] ISR_ADDR   = 12'h040
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irq,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  output logic [3:0]        state,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] ac,
  output logic              intEn
);

  ctrlStrobes_t strb;
  seqState_e    curState;

  icycle_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .irq      (irq),
    .ir       (ir),
    .curState (curState),
    .intEn    (intEn),
    .strb     (strb)
  );

  icycle_dpath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .START_ADDR (START_ADDR),
    .SAVE_ADDR  (SAVE_ADDR),
    .ISR_ADDR   (ISR_ADDR)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .memRdata (memRdata),
    .mar      (memAddr),
    .memWdata (memWdata),
    .pc       (pc),
    .ir       (ir),
    .ac       (ac)
  );

  assign memRd = strb.memRd;
  assign memWr = strb.memWr;
  assign state = curState;

endmodule

// File: rtl/icycle_seq_chk.sv
module icycle_seq_chk
  import icycle_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h008,
  parameter logic [ADDR_W-1:0] ISR_ADDR  = 12'h040
) (
  input logic              clk,
  input logic              rstN,
  input logic              irq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRd,
  input logic              memWr,
  input logic [3:0]        state,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] ir,
  input logic              intEn
);

  a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  a_r2_fetch_read: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FRD) |-> (memRd && memAddr == pc));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FLAT) |=> (pc == $past(pc) + 1'b1));

  a_r5_no_indirect: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEC && ir[DATA_W-2:DATA_W-4] == OP_REG) |=> (state == ST_EX0));

  a_r8_int_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INT0) |-> (intEn && $past(irq)));

  a_r9_order_0: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INT0) |=> (state == ST_INT1 && !intEn));

  a_r9_order_1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INT1) |=> (state == ST_INT2 && memAddr == SAVE_ADDR));

  a_r9_order_2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INT2) |=> (state == ST_INT3 && pc == ISR_ADDR));

  a_r9_save_write: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INT3) |-> (memWr && memAddr == SAVE_ADDR));

  a_r9_resume: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INT3) |=> (state == ST_FADR));

endmodule

bind icycle_seq icycle_seq_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .SAVE_ADDR (SAVE_ADDR),
  .ISR_ADDR  (ISR_ADDR)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .irq     (irq),
  .memAddr (memAddr),
  .memRd   (memRd),
  .memWr   (memWr),
  .state   (state),
  .pc      (pc),
  .ir      (ir),
  .intEn   (intEn)
);

// File: tb/icycle_seq_test.sv
`timescale 1ns/1ps
module icycle_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] memRdata;
  logic [11:0] memAddr;
  logic        memRd, memWr;
  logic [15:0] memWdata;
  logic [3:0]  state;
  logic [11:0] pc;
  logic [15:0] ir, ac;
  logic        intEn;

  always #2 clk = ~clk;

  icycle_seq uut (
    .clk(clk), .rstN(rstN), .irq(irq), .memRdata(memRdata),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .state(state), .pc(pc), .ir(ir), .ac(ac), .intEn(intEn)
  );

  logic [15:0] mem [0:255];
  logic        bothStrobes = 1'b0;

  always @(posedge clk) begin
    if (memWr) mem[memAddr[7:0]] <= memWdata;
    if (memRd) memRdata <= mem[memAddr[7:0]];
    if (memRd && memWr) bothStrobes <= 1'b1;
  end

  int checks = 0;
  int fails  = 0;
  int tick   = 0;
  bit done   = 0;
  int cyc;
  logic [3:0] trace [0:15];

  // {addr[12], instr[16], states[8], ac[16], pc after[12]}  (R3 encodings)
  localparam logic [63:0] VECS [11] = '{
    {12'h010, 16'h0080, 8'd8,  16'h0005, 12'h011},  // LOAD direct
    {12'h011, 16'h9082, 8'd11, 16'h0008, 12'h012},  // ADD indirect
    {12'h012, 16'h2083, 8'd6,  16'h0008, 12'h013},  // STORE
    {12'h013, 16'h7002, 8'd6,  16'h0009, 12'h014},  // INC
    {12'h014, 16'hF001, 8'd6,  16'h0000, 12'h015},  // CLR with bit 15 set
    {12'h015, 16'h8082, 8'd11, 16'h0003, 12'h016},  // LOAD indirect
    {12'h016, 16'h3018, 8'd6,  16'h0003, 12'h018},  // JUMP
    {12'h018, 16'h4090, 8'd7,  16'h0003, 12'h091},  // CALL
    {12'h091, 16'hB090, 8'd9,  16'h0003, 12'h019},  // JUMP indirect (return)
    {12'h019, 16'h1083, 8'd8,  16'h000B, 12'h01A},  // ADD direct
    {12'h01A, 16'h7000, 8'd6,  16'h000B, 12'h01B}   // NOP
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runInstr();
    cyc = 0;
    do begin
      @(negedge clk);
      if (cyc < 16) trace[cyc] = state;
      cyc++;
    end while (state != 4'd0 && cyc < 64);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    tick++;
    if (tick > 20000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", tick);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h7000;
    mem[8'h17] = 16'h7001;
    mem[8'h80] = 16'h0005;
    mem[8'h81] = 16'h0003;
    mem[8'h82] = 16'h0081;
    mem[8'h83] = 16'h0000;
    mem[8'h90] = 16'h0000;
    mem[8'h08] = 16'h0000;
    for (int i = 0; i < 11; i++) mem[VECS[i][59:52]] = VECS[i][51:36];
    mem[8'h1B] = 16'h7003;  // enable interrupts
    mem[8'h40] = 16'h7002;  // service routine: INC
    mem[8'h41] = 16'h7003;  // enable
    mem[8'h42] = 16'h7005;  // return
    mem[8'h1C] = 16'h7004;  // disable
    mem[8'h1D] = 16'h7000;  // NOP

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset pc", pc, 12'h010);
    chk("R1 reset state", state, 4'd0);
    chk("R1 reset intEn", intEn, 1'b0);
    chk("R1 reset strobes", {memRd, memWr}, 2'b00);
    rstN = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 11; i++) begin
      runInstr();
      if (i == 0) begin
        chk("R1 first fetch starts at once", trace[0], 4'd1);
        chk("R2 fetch order", {trace[1], trace[2], trace[3]}, {4'd2, 4'd3, 4'd4});
      end
      if (i == 1) chk("R4 indirect states", {trace[4], trace[5], trace[6]}, {4'd5, 4'd6, 4'd7});
      chk($sformatf("R6 states vec %0d", i), cyc, VECS[i][35:28]);
      chk($sformatf("R2 ir vec %0d", i), ir, VECS[i][51:36]);
      chk($sformatf("R7 ac vec %0d", i), ac, VECS[i][27:12]);
      chk($sformatf("R7 pc vec %0d", i), pc, VECS[i][11:0]);
      if (i == 4) chk("R5 no indirect for opcode 7", trace[4], 4'd8);
    end
    chk("R7 store result", mem[8'h83], 16'h0008);
    chk("R7 call return address", mem[8'h90], 16'h0019);

    // R8: enable instruction with request pending takes interrupt at once
    irq = 1'b1;
    runInstr();
    chk("R8 enable+request states", cyc, 10);
    chk("R9 interrupt order", {trace[5], trace[6], trace[7], trace[8]},
        {4'd12, 4'd13, 4'd14, 4'd15});
    chk("R9 pc to service routine", pc, 12'h040);
    chk("R9 enable cleared", intEn, 1'b0);
    chk("R9 saved pc", mem[8'h08], 16'h001C);

    // R10: request held while disabled
    runInstr();
    chk("R10 no interrupt while disabled", cyc, 6);
    chk("R10 pc", pc, 12'h041);
    chk("R10 ac", ac, 16'h000C);

    irq = 1'b0;
    runInstr();
    chk("R3 enable op", intEn, 1'b1);

    // R11: return from interrupt
    runInstr();
    chk("R11 return states", cyc, 9);
    chk("R11 pc restored", pc, 12'h01C);

    // R8: disable instruction with request pending takes no interrupt
    irq = 1'b1;
    runInstr();
    chk("R8 disable+request states", cyc, 6);
    chk("R8 enable after disable", intEn, 1'b0);
    runInstr();
    chk("R10 held request disabled", cyc, 6);
    chk("R10 pc after nop", pc, 12'h01E);

    chk("R12 strobes exclusive", bothStrobes, 1'b0);

    done = 1;
    summary();
    $finish;
  end

endmodule